// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence for one read or write burst of a synchronous DRAM. When a start request arrives it captures a start column, a burst length code and a wrap order. From the next clock on it emits one column address per clock, together with a valid flag and a flag that marks the final beat. The generator sits between a command scheduler, which decides when a column access begins, and the address pins of the memory. It also presents each column already placed on the multiplexed address bus. On that bus the auto-precharge position is kept clear of the column count.

Two orders are supported. In sequential order, only the low log2(BL) bits of the column count up, and they wrap inside the block of BL columns that holds the start column. In interleaved order, those low bits are the start bits XOR the beat number. In both orders the upper column bits never change during a burst. A new start request may arrive on any clock. It cuts off whatever burst is running, so a controller can issue a random column on every cycle.

Top module: `sdram_burst_colgen`

## Requirements
- R1: The burst length code `blen_i` selects 2^code beats: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. With no new start, `valid_o` stays high for exactly that many consecutive cycles.
- R2: With `order_i` = 0 (sequential), beat k carries the start column with its low log2(BL) bits replaced by (start low bits + k) mod BL. The bits above stay equal to the start column.
- R3: With `order_i` = 1 (interleaved), beat k carries the start column with its low log2(BL) bits replaced by (start low bits XOR k). The bits above stay equal to the start column.
- R4: A burst length of 1 emits only the start column, for one cycle, with `last_o` high on that same beat.
- R5: A start request on any cycle, including one in the middle of a burst, ends the current burst. Beat 0 of the new burst appears on the next cycle.
- R6: Length and order are captured at the start. Changes on `blen_i` and `order_i` while `start_i` is low have no effect on the burst in progress.
- R7: After the final beat, `valid_o` and `last_o` stay low until the next start request.
- R8: While reset is held, `valid_o` and `last_o` are low.
- R9: `addr_o` places column bits 9..0 on address bits 9..0 and column bit 10 on address bit 11. Address bits 10 and 12 are always 0.
- R10: `last_o` is high only on the final beat of a burst, and only while `valid_o` is high.
- R11: All inputs are sampled on the rising clock edge. The outputs are registered and change only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a new burst, aborting any burst in progress |
| start_col_i | input | 11 | Start column of the new burst |
| blen_i | input | 2 | Burst length code, 2^code beats |
| order_i | input | 1 | Wrap order: 0 sequential, 1 interleaved |
| col_o | output | 11 | Column address of the current beat |
| addr_o | output | 13 | Column placed on the multiplexed address bus |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | The current beat is the final one |

## Verification
The bench targets start columns that do not sit at the start of their aligned block. There, a generator that carries out of the low bits would step into the next block, and one that confuses the two orders would present the right set of columns in the wrong sequence. It restarts bursts after one, two or several beats and on consecutive cycles, because a restart that does not reset the beat count starts in the middle of the new block. It also changes length and order while a burst is running, which catches a generator that reads live inputs instead of captured ones. Full-ones columns confirm that address bit 10 stays clear even when every column bit is set.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

   // Wrap order selector values
   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_ILV = 1'b1
   } order_e;

   // Default geometry: 11-bit column, 13-bit address bus, bit 10 reserved
   localparam int DEF_COL_W    = 11;
   localparam int DEF_ADDR_W   = 13;
   localparam int DEF_SKIP_BIT = 10;
   localparam int DEF_MAX_LOG  = 3;

endpackage

// File: rtl/sdram_colgen_ctrl.sv
module sdram_colgen_ctrl #(
   parameter int COL_W   = 11,
   parameter int MAX_LOG = 3,
   localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [COL_W-1:0]   start_col_i,
   input  logic [LOG_W-1:0]   blen_i,
   input  logic               order_i,
   output logic [COL_W-1:0]   base_o,
   output logic [LOG_W-1:0]   blog_o,
   output logic               order_o,
   output logic [MAX_LOG-1:0] beat_o,
   output logic               valid_o,
   output logic               last_o
);

   logic [COL_W-1:0]   base_q;
   logic [LOG_W-1:0]   blog_q;
   logic               order_q;
   logic [MAX_LOG-1:0] beat_q;
   logic               valid_q;
   logic [MAX_LOG-1:0] final_beat;
   logic               at_final;

   // Final beat index is BL-1: the low blog_q bits set
   assign final_beat = ~({MAX_LOG{1'b1}} << blog_q);
   assign at_final   = (beat_q == final_beat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         blog_q  <= '0;
         order_q <= 1'b0;
         beat_q  <= '0;
         valid_q <= 1'b0;
      end else if (start_i) begin
         base_q  <= start_col_i;
         blog_q  <= blen_i;
         order_q <= order_i;
         beat_q  <= '0;
         valid_q <= 1'b1;
      end else if (valid_q) begin
         if (at_final) begin
            valid_q <= 1'b0;
         end else begin
            beat_q <= beat_q + 1'b1;
         end
      end
   end

   assign base_o  = base_q;
   assign blog_o  = blog_q;
   assign order_o = order_q;
   assign beat_o  = beat_q;
   assign valid_o = valid_q;
   assign last_o  = valid_q & at_final;

   // R5: a start always yields beat 0 on the next cycle
   p_restart_beat0_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && beat_o == '0));

   // R6: captured mode holds while no start arrives
   p_mode_held_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !start_i) |=> ($stable(blog_o) && $stable(order_o) && $stable(base_o)));

   // R7: idle after the final beat unless restarted
   p_idle_after_last_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> (!valid_o && !last_o));

   // R7: idle stays idle without a start
   p_idle_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && !start_i) |=> !valid_o);

   // R10: last only while valid
   p_last_in_burst_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   // R1: mid-burst beats advance by one
   p_beat_step_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o && !start_i) |=> (beat_o == $past(beat_o) + 1'b1));

endmodule

// File: rtl/sdram_colgen_order.sv
module sdram_colgen_order #(
   parameter int COL_W   = 11,
   parameter int MAX_LOG = 3,
   parameter bit HAS_ILV = 1'b1,
   localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
   input  logic [COL_W-1:0]   base_i,
   input  logic [LOG_W-1:0]   blog_i,
   input  logic               order_i,
   input  logic [MAX_LOG-1:0] beat_i,
   output logic [COL_W-1:0]   col_o
);

   logic [MAX_LOG-1:0] low_base;
   logic [MAX_LOG-1:0] low_mask;
   logic [MAX_LOG-1:0] seq_low;
   logic [MAX_LOG-1:0] pick_low;
   logic [MAX_LOG-1:0] new_low;

   assign low_base = base_i[MAX_LOG-1:0];
   assign low_mask = ~({MAX_LOG{1'b1}} << blog_i);
   // Carry out of the masked field is discarded by the mask below
   assign seq_low  = low_base + beat_i;

   generate
      if (HAS_ILV) begin : g_both_orders
         logic [MAX_LOG-1:0] ilv_low;
         assign ilv_low  = low_base ^ beat_i;
         assign pick_low = order_i ? ilv_low : seq_low;
      end else begin : g_seq_only
         logic unused_order;
         assign unused_order = order_i;
         assign pick_low     = seq_low;
      end
   endgenerate

   assign new_low = (low_base & ~low_mask) | (pick_low & low_mask);
   assign col_o   = {base_i[COL_W-1:MAX_LOG], new_low};

endmodule

// File: rtl/sdram_colgen_pinmap.sv
module sdram_colgen_pinmap #(
   parameter int COL_W    = 11,
   parameter int ADDR_W   = 13,
   parameter int SKIP_BIT = 10
) (
   input  logic [COL_W-1:0]  col_i,
   output logic [ADDR_W-1:0] addr_o
);

   generate
      for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_pin
         if (gi < SKIP_BIT) begin : g_low
            assign addr_o[gi] = col_i[gi];
         end else if (gi == SKIP_BIT) begin : g_skip
            assign addr_o[gi] = 1'b0;
         end else if (gi - 1 < COL_W) begin : g_high
            assign addr_o[gi] = col_i[gi-1];
         end else begin : g_pad
            assign addr_o[gi] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
   import sdram_colgen_pkg::*;
#(
   parameter int COL_W    = DEF_COL_W,
   parameter int ADDR_W   = DEF_ADDR_W,
   parameter int SKIP_BIT = DEF_SKIP_BIT,
   parameter int MAX_LOG  = DEF_MAX_LOG,
   parameter bit HAS_ILV  = 1'b1,
   localparam int LOG_W   = $clog2(MAX_LOG + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [COL_W-1:0]  start_col_i,
   input  logic [LOG_W-1:0]  blen_i,
   input  logic              order_i,
   output logic [COL_W-1:0]  col_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              valid_o,
   output logic              last_o
);

   // Elaboration-time parameter checks
   generate
      if (MAX_LOG < 1) begin : g_bad_log
         $error("MAX_LOG must be at least 1");
      end
      if ((1 << LOG_W) != MAX_LOG + 1) begin : g_bad_code
         $error("MAX_LOG + 1 must be a power of two so every length code is legal");
      end
      if (COL_W <= MAX_LOG) begin : g_bad_col
         $error("COL_W must exceed MAX_LOG");
      end
      if (SKIP_BIT > COL_W || ADDR_W < COL_W + 1) begin : g_bad_map
         $error("address bus too narrow for column plus reserved bit");
      end
   endgenerate

   logic [COL_W-1:0]   base_w;
   logic [LOG_W-1:0]   blog_w;
   logic               order_w;
   logic [MAX_LOG-1:0] beat_w;

   sdram_colgen_ctrl #(
      .COL_W   (COL_W),
      .MAX_LOG (MAX_LOG)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .start_col_i (start_col_i),
      .blen_i      (blen_i),
      .order_i     (order_i),
      .base_o      (base_w),
      .blog_o      (blog_w),
      .order_o     (order_w),
      .beat_o      (beat_w),
      .valid_o     (valid_o),
      .last_o      (last_o)
   );

   sdram_colgen_order #(
      .COL_W   (COL_W),
      .MAX_LOG (MAX_LOG),
      .HAS_ILV (HAS_ILV)
   ) u_order (
      .base_i  (base_w),
      .blog_i  (blog_w),
      .order_i (order_w),
      .beat_i  (beat_w),
      .col_o   (col_o)
   );

   sdram_colgen_pinmap #(
      .COL_W    (COL_W),
      .ADDR_W   (ADDR_W),
      .SKIP_BIT (SKIP_BIT)
   ) u_pinmap (
      .col_i  (col_o),
      .addr_o (addr_o)
   );

   // R2/R3: bits above the burst field never move within a burst
   p_upper_fixed_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o && !start_i) |=>
         (col_o[COL_W-1:MAX_LOG] == $past(col_o[COL_W-1:MAX_LOG])));

   // R4: a one-beat burst is last on its only beat
   p_single_beat_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && blen_i == '0) |=> last_o);

   // R5: the first beat repeats the captured start column
   p_first_col_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (col_o == $past(start_col_i)));

   // R8: nothing valid while in reset
   p_reset_quiet_r8 : assert property (@(posedge clk)
      !rst_n |-> (!valid_o && !last_o));

endmodule

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [10:0] start_col_i = '0;
   logic [1:0]  blen_i = '0;
   logic        order_i = 1'b0;
   logic [10:0] col_o;
   logic [12:0] addr_o;
   logic        valid_o;
   logic        last_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   sdram_burst_colgen u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .start_col_i (start_col_i),
      .blen_i      (blen_i),
      .order_i     (order_i),
      .col_o       (col_o),
      .addr_o      (addr_o),
      .valid_o     (valid_o),
      .last_o      (last_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Expected column from the ordering rules
   function automatic int exp_col(input int base, input int blog, input bit ilv, input int k);
      int bl, lo, nl;
      bl = 1 << blog;
      lo = base % bl;
      nl = ilv ? (lo ^ k) : ((lo + k) % bl);
      return base - lo + nl;
   endfunction

   // Expected address bus image of a column
   function automatic int exp_addr(input int col);
      int a;
      a = col % 1024;
      if ((col / 1024) % 2 == 1) a = a + 2048;
      return a;
   endfunction

   // Reference state, updated from sampled inputs at each rising edge
   bit m_valid = 1'b0;
   int m_base = 0, m_blog = 0, m_k = 0;
   bit m_ilv = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid <= 1'b0;
      end else if (start_i) begin
         m_valid <= 1'b1;
         m_base  <= int'(start_col_i);
         m_blog  <= int'(blen_i);
         m_ilv   <= order_i;
         m_k     <= 0;
      end else if (m_valid) begin
         if (m_k == (1 << m_blog) - 1) m_valid <= 1'b0;
         else m_k <= m_k + 1;
      end
   end

   // Per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R1/R7 valid", int'(valid_o), int'(m_valid));
         check((m_blog == 0) ? "R4 last" : "R10 last", int'(last_o),
               int'(m_valid && m_k == (1 << m_blog) - 1));
         if (m_valid) begin
            check((m_blog == 0) ? "R4 col" : (m_ilv ? "R3 col" : "R2 col"),
                  int'(col_o), exp_col(m_base, m_blog, m_ilv, m_k));
            check("R9 addr", int'(addr_o), exp_addr(int'(col_o)));
         end
      end
   end

   task automatic drive(input bit s, input int c, input int b, input bit o);
      @(negedge clk);
      start_i     = s;
      start_col_i = 11'(c);
      blen_i      = 2'(b);
      order_i     = o;
   endtask

   // Check one beat at the next negedge, then release start
   task automatic beat(input string tag, input int exp_c, input bit exp_last);
      @(negedge clk);
      start_i = 1'b0;
      check(tag, int'(col_o), exp_c);
      check({tag, " last"}, int'(last_o), int'(exp_last));
   endtask

   task automatic idle_check(input string tag);
      @(negedge clk);
      check(tag, int'(valid_o), 0);
      check({tag, " last"}, int'(last_o), 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired");
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin : stim
      int seed;
      seed = 32'h5D3A_11C7;
      void'($urandom(seed));

      // R8: reset state
      repeat (3) begin
         @(negedge clk);
         check("R8 valid in reset", int'(valid_o), 0);
         check("R8 last in reset", int'(last_o), 0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      idle_check("R7 idle after reset");

      // R2: sequential BL8 from 0x0D wraps inside 0x08..0x0F
      drive(1, 'h0D, 3, 0);
      beat("R2 seq b0", 'h0D, 0);
      beat("R2 seq b1", 'h0E, 0);
      beat("R2 seq b2", 'h0F, 0);
      beat("R2 seq b3", 'h08, 0);
      beat("R2 seq b4", 'h09, 0);
      beat("R2 seq b5", 'h0A, 0);
      beat("R2 seq b6", 'h0B, 0);
      beat("R2 seq b7", 'h0C, 1);
      idle_check("R7 after seq");

      // R3: interleaved BL8 from 0x0D
      drive(1, 'h0D, 3, 1);
      beat("R3 ilv b0", 'h0D, 0);
      beat("R3 ilv b1", 'h0C, 0);
      beat("R3 ilv b2", 'h0F, 0);
      beat("R3 ilv b3", 'h0E, 0);
      beat("R3 ilv b4", 'h09, 0);
      beat("R3 ilv b5", 'h08, 0);
      beat("R3 ilv b6", 'h0B, 0);
      beat("R3 ilv b7", 'h0A, 1);
      idle_check("R7 after ilv");

      // R4 and R9: single beat at all-ones column, bit 10 kept clear
      drive(1, 'h7FF, 0, 0);
      beat("R4 single", 'h7FF, 1);
      check("R9 addr all ones", int'(addr_o), 'h0BFF);
      idle_check("R4 single ends");

      // R5: restart mid-burst into interleaved BL4 (R11: beat 0 next cycle)
      drive(1, 'h100, 3, 0);
      beat("R5 pre b0", 'h100, 0);
      beat("R5 pre b1", 'h101, 0);
      start_i = 1'b1; start_col_i = 11'h2A5; blen_i = 2'd2; order_i = 1'b1;
      beat("R5 new b0", 'h2A5, 0);
      beat("R5 new b1", 'h2A4, 0);
      beat("R5 new b2", 'h2A7, 0);
      beat("R5 new b3", 'h2A6, 1);
      idle_check("R7 after restart");

      // R6: mode inputs change mid-burst without start
      drive(1, 'h006, 1, 0);
      @(negedge clk);
      check("R6 b0", int'(col_o), 'h006);
      start_i = 1'b0; blen_i = 2'd3; order_i = 1'b1;
      beat("R6 b1 ignores new mode", 'h007, 1);
      idle_check("R6 burst not lengthened");

      // R1: BL2 sequential at odd column wraps back
      drive(1, 'h403, 1, 0);
      beat("R1 bl2 b0", 'h403, 0);
      beat("R1 bl2 b1", 'h402, 1);
      idle_check("R1 bl2 length");

      // Random mix, checked by the per-cycle reference
      for (int i = 0; i < 4000; i++) begin
         drive(($urandom % 4) == 0, $urandom % 2048, $urandom % 4, $urandom % 2);
      end
      drive(0, 0, 0, 0);
      repeat (10) @(negedge clk);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule